// File: doc/BRIEF.md
# Grouped Clock-Source Protection Selector

This block chooses one of three timing groups (master, slave and stand-by) for a line card. Each group is a clock plus its frame sync, and the two always move together. A fast activity monitor on each input clock counts cycles of the local reference clock between input edges. An input is marked failed when it stays quiet too long. It is marked usable again only after a run of edges with no gap.

Without the force input, the preference order is master, then slave, then stand-by. With the force input high, slave and master swap places, and stand-by stays last. The force input therefore only decides between master and slave. The block is revertive: a group that qualifies again takes back its place in the order. When no group is usable after lock, the block holds its last selection and reports holdover. It leaves free-run only when a usable group is present and the lock indication from the downstream loop is high. A sticky interrupt records every change of the selection or of any per-input valid bit.

Top module: `clk_src_guard`

## Requirements
- R1: After reset, grp_sel is 0 (master), mode is 0 (free-run), src_valid is 000 and irq is 0.
- R2: An input's src_valid bit falls when that clock shows no edge for TIMEOUT_CYC reference cycles. The clock is seen through a two-stage synchronizer, and both edges count.
- R3: A failed input sets its src_valid bit only after QUAL_EDGES consecutive edges, each arriving before the timeout.
- R4: With force_slave low, grp_sel is the first valid group in the order master (0), slave (1), stand-by (2). src_valid bit 0 is master, bit 1 is slave and bit 2 is stand-by.
- R5: With force_slave high, the order becomes slave, master, stand-by, so the force input never picks stand-by while master or slave is valid.
- R6: clk_out and sync_out both come from the group named by grp_sel.
- R7: When no input is valid and mode is not free-run, mode becomes 2 (holdover) and grp_sel keeps its last value.
- R8: mode leaves 0 (free-run) for 1 (locked) only when at least one input is valid and lock_ok is high.
- R9: From holdover, mode returns to 1 (locked) as soon as any input is valid, with or without lock_ok, and grp_sel takes the highest-priority valid group.
- R10: irq is set when grp_sel or any src_valid bit changes, stays set, and is cleared by a one-cycle irq_clr pulse. A change in the same cycle as the clear keeps it set.
- R11: Selection is revertive: when master qualifies again with force_slave low, grp_sel returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 3 | Group clocks: bit 0 master, bit 1 slave, bit 2 stand-by |
| src_sync | input | 3 | Group frame syncs, same bit order as src_clk |
| force_slave | input | 1 | Prefer slave over master |
| lock_ok | input | 1 | Lock indication from the downstream loop |
| irq_clr | input | 1 | Clear strobe for irq |
| grp_sel | output | 2 | Selected group: 0 master, 1 slave, 2 stand-by |
| mode | output | 2 | 0 free-run, 1 locked, 2 holdover |
| src_valid | output | 3 | Per-input valid bits |
| clk_out | output | 1 | Clock of the selected group |
| sync_out | output | 1 | Frame sync of the selected group |
| irq | output | 1 | Sticky change flag |

## Verification
The assertions check on every cycle that the select and mode codes stay legal. They also check that a monitor drops its valid bit on the cycle after the timeout count is reached, that a force with a valid slave selects slave, that free-run holds while lock_ok is low, that a loss of all inputs after lock gives holdover, and that irq stays set until cleared. Only the bench scenarios can show the full fallback and revert sequences, the qualification delay in edges, the routing of clock and sync together, and the interrupt set and clear handshake seen from the ports.

// File: rtl/clk_src_guard_pkg.sv
package clk_src_guard_pkg;
  localparam int NUM_SRC = 3;

  localparam logic [1:0] GRP_MASTER = 2'd0;
  localparam logic [1:0] GRP_SLAVE  = 2'd1;
  localparam logic [1:0] GRP_STBY   = 2'd2;

  localparam logic [1:0] MODE_FREE   = 2'd0;
  localparam logic [1:0] MODE_LOCKED = 2'd1;
  localparam logic [1:0] MODE_HOLD   = 2'd2;

  // k-th preferred source; force swaps master and slave only
  function automatic logic [1:0] rank_src(input logic frc, input int k);
    if (frc && k < 2) return 2'(1 - k);
    return 2'(k);
  endfunction
endpackage

// File: rtl/src_activity_mon.sv
module src_activity_mon #(
  parameter int TIMEOUT_CYC = 16,
  parameter int QUAL_EDGES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_in,
  output logic valid
);
  localparam int GW = $clog2(TIMEOUT_CYC + 1);
  localparam int QW = $clog2(QUAL_EDGES + 1);

  logic [2:0]    smp_q;
  logic [GW-1:0] gap_q, gap_n;
  logic [QW-1:0] qual_q, qual_n;
  logic          valid_q, valid_n;
  logic          edge_seen, timeout_hit;

  assign edge_seen   = smp_q[1] ^ smp_q[2];
  assign timeout_hit = !edge_seen && (gap_q == GW'(TIMEOUT_CYC - 1));

  always_comb begin
    gap_n   = gap_q;
    qual_n  = qual_q;
    valid_n = valid_q;
    if (edge_seen) begin
      gap_n = '0;
    end else if (gap_q != GW'(TIMEOUT_CYC)) begin
      gap_n = gap_q + 1'b1;
    end
    if (timeout_hit) begin
      valid_n = 1'b0;
      qual_n  = '0;
    end else if (edge_seen && !valid_q) begin
      if (qual_q == QW'(QUAL_EDGES - 1)) begin
        valid_n = 1'b1;
        qual_n  = '0;
      end else begin
        qual_n = qual_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      gap_q   <= '0;
      qual_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      smp_q   <= {smp_q[1:0], mon_in};
      gap_q   <= gap_n;
      qual_q  <= qual_n;
      valid_q <= valid_n;
    end
  end

  assign valid = valid_q;

  // R2: a gap reaching the timeout drops the valid bit on the next cycle
  p_timeout_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == GW'(TIMEOUT_CYC - 1) && !edge_seen) |=> !valid_q);

  // R3: the valid bit never rises without an edge in the cycle before
  p_rise_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(smp_q[1] ^ smp_q[2]));
endmodule

// File: rtl/src_arbiter.sv
module src_arbiter
  import clk_src_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] valid,
  input  logic               force_slave,
  input  logic               lock_ok,
  output logic [1:0]         sel,
  output logic [1:0]         mode
);
  logic [1:0] sel_q, sel_n;
  logic [1:0] mode_q, mode_n;
  logic       any_valid;

  assign any_valid = |valid;

  always_comb begin
    sel_n = sel_q;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (valid[rank_src(force_slave, k)]) sel_n = rank_src(force_slave, k);
    end
  end

  always_comb begin
    mode_n = mode_q;
    if (!any_valid) begin
      mode_n = (mode_q == MODE_FREE) ? MODE_FREE : MODE_HOLD;
    end else if (lock_ok || mode_q != MODE_FREE) begin
      mode_n = MODE_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= GRP_MASTER;
      mode_q <= MODE_FREE;
    end else begin
      sel_q  <= sel_n;
      mode_q <= mode_n;
    end
  end

  assign sel  = sel_q;
  assign mode = mode_q;

  // R4: the select code is always a legal group
  p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != 2'd3);

  // R5: force with a valid slave selects slave
  p_force_slave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_slave && valid[1]) |=> sel_q == GRP_SLAVE);

  // R7: losing every input after lock gives holdover
  p_holdover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_valid && mode_q != MODE_FREE) |=> mode_q == MODE_HOLD);

  // R8: free-run holds while the loop reports no lock
  p_free_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE && !lock_ok) |=> mode_q == MODE_FREE);

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);
endmodule

// File: rtl/clk_src_guard.sv
module clk_src_guard
  import clk_src_guard_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int QUAL_EDGES  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [NUM_SRC-1:0] src_sync,
  input  logic               force_slave,
  input  logic               lock_ok,
  input  logic               irq_clr,
  output logic [1:0]         grp_sel,
  output logic [1:0]         mode,
  output logic [NUM_SRC-1:0] src_valid,
  output logic               clk_out,
  output logic               sync_out,
  output logic               irq
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] valid_w, valid_d;
  logic [1:0]         sel_w, sel_d;
  logic               irq_q, irq_n, chg;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mon
    src_activity_mon #(
      .TIMEOUT_CYC(TIMEOUT_CYC),
      .QUAL_EDGES (QUAL_EDGES)
    ) u_mon (
      .clk   (clk),
      .rst_n (rst_int_n),
      .mon_in(src_clk[g]),
      .valid (valid_w[g])
    );
  end

  src_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .valid      (valid_w),
    .force_slave(force_slave),
    .lock_ok    (lock_ok),
    .sel        (sel_w),
    .mode       (mode)
  );

  assign chg = (valid_w != valid_d) || (sel_w != sel_d);

  always_comb begin
    irq_n = irq_q;
    if (chg)          irq_n = 1'b1;
    else if (irq_clr) irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_d <= '0;
      sel_d   <= GRP_MASTER;
      irq_q   <= 1'b0;
    end else begin
      valid_d <= valid_w;
      sel_d   <= sel_w;
      irq_q   <= irq_n;
    end
  end

  // clock and sync of a group are switched as one pair
  always_comb begin
    case (sel_w)
      GRP_SLAVE: begin clk_out = src_clk[1]; sync_out = src_sync[1]; end
      GRP_STBY:  begin clk_out = src_clk[2]; sync_out = src_sync[2]; end
      default:   begin clk_out = src_clk[0]; sync_out = src_sync[0]; end
    endcase
  end

  assign grp_sel   = sel_w;
  assign src_valid = valid_w;
  assign irq       = irq_q;

  // R10: the flag holds until a clear strobe
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_q && !irq_clr) |=> irq_q);

  // R10: a selection change always raises the flag
  p_irq_on_sel_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_w != sel_d) |=> irq_q);
endmodule

// File: tb/tb_clk_src_guard.sv
module tb_clk_src_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_clk = '0;
  logic [2:0] src_sync = '0;
  logic [2:0] src_en = '0;
  logic       force_slave = 1'b0;
  logic       lock_ok = 1'b0;
  logic       irq_clr = 1'b0;
  logic [1:0] grp_sel, mode;
  logic [2:0] src_valid;
  logic       clk_out, sync_out, irq;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;
  logic       div_q = 1'b0;

  always #2.5 clk = ~clk;

  clk_src_guard dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src_sync(src_sync),
    .force_slave(force_slave), .lock_ok(lock_ok), .irq_clr(irq_clr),
    .grp_sel(grp_sel), .mode(mode), .src_valid(src_valid),
    .clk_out(clk_out), .sync_out(sync_out), .irq(irq)
  );

  // enabled sources toggle every second reference cycle
  always @(negedge clk) begin
    div_q <= ~div_q;
    if (div_q) src_clk <= src_clk ^ src_en;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {en[2:0], force, lock, sel[1:0], mode[1:0], valid[2:0]}
  localparam logic [11:0] VEC [12] = '{
    {3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000},  // R1/R8 nothing active
    {3'b111, 1'b0, 1'b0, 2'd0, 2'd0, 3'b111},  // R8 valid but no lock
    {3'b111, 1'b0, 1'b1, 2'd0, 2'd1, 3'b111},  // R8 lock
    {3'b110, 1'b0, 1'b1, 2'd1, 2'd1, 3'b110},  // R4 master lost
    {3'b100, 1'b0, 1'b1, 2'd2, 2'd1, 3'b100},  // R4 stand-by
    {3'b000, 1'b0, 1'b1, 2'd2, 2'd2, 3'b000},  // R7 holdover
    {3'b010, 1'b0, 1'b0, 2'd1, 2'd1, 3'b010},  // R9 back without lock
    {3'b011, 1'b0, 1'b0, 2'd0, 2'd1, 3'b011},  // R11 revert
    {3'b011, 1'b1, 1'b0, 2'd1, 2'd1, 3'b011},  // R5 force
    {3'b101, 1'b1, 1'b0, 2'd0, 2'd1, 3'b101},  // R5 forced slave gone
    {3'b100, 1'b1, 1'b0, 2'd2, 2'd1, 3'b100},  // R5 fallback
    {3'b111, 1'b0, 1'b1, 2'd0, 2'd1, 3'b111}   // R4 all back
  };

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    check("R1 sel", grp_sel, 0);
    check("R1 mode", mode, 0);
    check("R1 valid", src_valid, 0);
    check("R1 irq", irq, 0);

    foreach (VEC[i]) begin
      src_en      = VEC[i][11:9];
      force_slave = VEC[i][8];
      lock_ok     = VEC[i][7];
      idle(64);
      check($sformatf("R4/R5 sel step %0d", i), grp_sel, VEC[i][6:5]);
      check($sformatf("R7/R8/R9 mode step %0d", i), mode, VEC[i][4:3]);
      check($sformatf("R2/R3 valid step %0d", i), src_valid, VEC[i][2:0]);
    end

    // R6: master selected, sync and clock follow master only
    src_sync = 3'b110;
    idle(1);
    check("R6 sync from master", sync_out, 0);
    check("R6 clk from master", clk_out, src_clk[0]);
    src_sync = 3'b001;
    idle(1);
    check("R6 sync follows master", sync_out, 1);

    // R10: clear then a new change sets the flag again
    check("R10 irq pending", irq, 1);
    irq_clr = 1'b1;
    idle(1);
    irq_clr = 1'b0;
    idle(1);
    check("R10 irq cleared", irq, 0);

    // R2: master silent; still valid at 8 cycles, failed by 30
    src_en = 3'b110;
    idle(8);
    check("R2 valid before timeout", src_valid[0], 1);
    check("R10 no change no irq", irq, 0);
    idle(22);
    check("R2 failed after timeout", src_valid[0], 0);
    check("R10 irq on valid change", irq, 1);
    check("R4 slave after master fail", grp_sel, 1);

    // R3: restart master; 4 edges are not enough, 8 are
    src_en = 3'b111;
    idle(10);
    check("R3 not yet qualified", src_valid[0], 0);
    idle(30);
    check("R3 qualified", src_valid[0], 1);
    check("R11 master reselected", grp_sel, 0);

    // R10: clear strobe in a cycle where selection changes keeps flag
    idle(2);
    irq_clr = 1'b1;
    idle(1);
    irq_clr = 1'b0;
    check("R10 cleared again", irq, 0);
    force_slave = 1'b1;
    irq_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_clr = 1'b0;
    idle(1);
    check("R10 change beats clear", irq, 1);
    check("R5 forced slave", grp_sel, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule